// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of a dual-slope integrating converter. It runs from one free-running clock. It repeats a three-phase measurement cycle without pause: offset cancellation (autozero), input integration, and reference de-integration (read). For each phase it drives one enable for the matching analog switch, and exactly one of the three enables is high at any time. Both fixed phases last one full wrap of an internal counter.

The analog front end returns a single comparator bit, which the block resynchronizes. The comparator level seen on the final integration clock gives the input polarity. The block then selects a reference of the opposite sign for the read phase. The read phase counts clocks until the synchronized comparator changes state, or until a count ceiling is reached.

At the end of each read phase the block captures the count, the sign and an overrange flag, and pulses a valid strobe. The captured values stay unchanged through the following cycle, so display logic can use them at any time.

Top module: `dsadc_seq`

## Requirements
- R1: While the synchronous reset `rst` is high, and on the first clock after it, `az_en` is 1, `int_en`, `rd_en` and `ref_neg` are 0, and `res_mag`, `res_neg`, `res_over` and `res_vld` are all 0.
- R2: Exactly one of `az_en`, `int_en` and `rd_en` is high on every clock. The phases always follow the order autozero, integrate, read, autozero, with no idle clock between them.
- R3: The integrate phase lasts exactly `FIX_CYCLES` clocks. An autozero phase that follows a read phase also lasts exactly `FIX_CYCLES` clocks.
- R4: The twice-registered comparator level on the last integrate clock is stored. It drives `ref_neg` (1 = negative reference, used when the comparator was high) for the whole read phase. Outside read, `ref_neg` is 0.
- R5: The read phase ends on the first read clock in which the twice-registered comparator differs from its value on the previous clock. `res_mag` then holds that clock's 0-based index within the read phase. A comparator change applied during read clock k gives k+2.
- R6: `res_neg` is 1 when the stored polarity was low, that is, for a negative input. It is 0 otherwise.
- R7: If no comparator change occurs within `READ_MAX` read clocks, the read phase ends on its last clock. In that case `res_over` is 1 and `res_mag` equals `READ_MAX`. A change detected on that last clock takes priority, and `res_over` is then 0.
- R8: `res_vld` is a one-clock pulse on the first autozero clock after a read phase. `res_mag`, `res_neg` and `res_over` change only together with that pulse.
- R9: Comparator activity during autozero or integrate ends no phase. A glitch that has cleared before the last integrate clock does not change the stored polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_in | input | 1 | Asynchronous comparator bit from the analog front end |
| az_en | output | 1 | Autozero switch enable |
| int_en | output | 1 | Input-integrate switch enable |
| rd_en | output | 1 | Reference-read switch enable |
| ref_neg | output | 1 | Selects the negative reference during read |
| res_mag | output | CNT_W | Captured read count |
| res_neg | output | 1 | Captured sign (1 = negative input) |
| res_over | output | 1 | Captured overrange flag |
| res_vld | output | 1 | One-clock strobe marking a new capture |

## Verification
The bound checker tests the following on every clock:
- one-hot enables and the phase order;
- exact fixed-phase lengths, using a run counter;
- a steady reference select through read, and zero outside read;
- the pulse shape and placement of the strobe, and results that change only with the strobe;
- the result class chosen by crossing versus timeout.

Only the bench's scenarios can show that the captured magnitude equals the read-clock index of the comparator change, across a full sweep of change times and both polarities. The same applies to the sign matching the input polarity, to the boundary where a crossing on the last read clock beats the timeout, and to a glitch during integration being ignored.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

  typedef enum logic [1:0] {
    PH_AZ  = 2'd0,
    PH_INT = 2'd1,
    PH_RD  = 2'd2
  } phase_t;

  typedef struct packed {
    logic az;
    logic integ;
    logic rd;
  } sw_en_t;

  // Switch enables decoded from the phase: one-hot by construction of the decode
  function automatic sw_en_t phase_to_sw(phase_t ph);
    sw_en_t s;
    s.az    = (ph == PH_AZ);
    s.integ = (ph == PH_INT);
    s.rd    = (ph == PH_RD);
    return s;
  endfunction

  // Successor of a fixed-length phase
  function automatic phase_t next_fixed(phase_t ph);
    return (ph == PH_AZ) ? PH_INT : PH_RD;
  endfunction

  // Captured magnitude: ceiling value on timeout, otherwise the read index
  function automatic int unsigned capture_mag(logic timeout, int unsigned idx,
                                              int unsigned ceiling);
    return timeout ? ceiling : idx;
  endfunction

endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic chg
);
  logic [STAGES-1:0] chain;
  logic              lvl_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= din;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= chain[STAGES-1];
  end

  assign lvl = chain[STAGES-1];
  assign chg = lvl ^ lvl_q;
endmodule

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl
  import dsadc_pkg::*;
#(
  parameter int unsigned FIX_CYCLES = 1000,
  parameter int unsigned READ_MAX   = 2000,
  parameter int unsigned CNT_W      = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lvl,
  input  logic             chg,
  output phase_t           phase,
  output logic [CNT_W-1:0] cnt,
  output logic             pol,
  output logic             fix_done,
  output logic             cross_evt,
  output logic             tmo_evt
);
  localparam logic [CNT_W-1:0] FIX_LAST  = CNT_W'(FIX_CYCLES - 1);
  localparam logic [CNT_W-1:0] READ_LAST = CNT_W'(READ_MAX - 1);

  logic in_rd;

  assign in_rd     = (phase == PH_RD);
  assign fix_done  = !in_rd && (cnt == FIX_LAST);
  assign cross_evt = in_rd && chg;
  assign tmo_evt   = in_rd && !chg && (cnt == READ_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_AZ;
      cnt   <= '0;
      pol   <= 1'b0;
    end else if (fix_done) begin
      phase <= next_fixed(phase);
      cnt   <= '0;
      if (phase == PH_INT) pol <= lvl;
    end else if (cross_evt || tmo_evt) begin
      phase <= PH_AZ;
      cnt   <= '0;
    end else begin
      cnt   <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/dsadc_result.sv
module dsadc_result
  import dsadc_pkg::*;
#(
  parameter int unsigned READ_MAX = 2000,
  parameter int unsigned CNT_W    = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             read_end,
  input  logic             tmo_evt,
  input  logic             pol,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] res_mag,
  output logic             res_neg,
  output logic             res_over,
  output logic             res_vld
);
  always_ff @(posedge clk) begin
    if (rst) begin
      res_mag  <= '0;
      res_neg  <= 1'b0;
      res_over <= 1'b0;
      res_vld  <= 1'b0;
    end else begin
      res_vld <= read_end;
      if (read_end) begin
        res_mag  <= CNT_W'(capture_mag(tmo_evt, int'(cnt), READ_MAX));
        res_neg  <= !pol;
        res_over <= tmo_evt;
      end
    end
  end
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int unsigned FIX_CYCLES = 1000,
  parameter int unsigned READ_MAX   = 2000,
  localparam int unsigned SPAN      = (FIX_CYCLES > READ_MAX) ? FIX_CYCLES : READ_MAX,
  localparam int unsigned CNT_W     = $clog2(SPAN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_in,
  output logic             az_en,
  output logic             int_en,
  output logic             rd_en,
  output logic             ref_neg,
  output logic [CNT_W-1:0] res_mag,
  output logic             res_neg,
  output logic             res_over,
  output logic             res_vld
);
  logic             cmp_lvl;
  logic             cmp_chg;
  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic             pol;
  logic             fix_done;
  logic             cross_evt;
  logic             tmo_evt;
  logic             read_end;
  sw_en_t           sw;

  dsadc_sync #(.STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (cmp_in),
    .lvl (cmp_lvl),
    .chg (cmp_chg)
  );

  dsadc_ctrl #(
    .FIX_CYCLES (FIX_CYCLES),
    .READ_MAX   (READ_MAX),
    .CNT_W      (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .lvl       (cmp_lvl),
    .chg       (cmp_chg),
    .phase     (phase),
    .cnt       (cnt),
    .pol       (pol),
    .fix_done  (fix_done),
    .cross_evt (cross_evt),
    .tmo_evt   (tmo_evt)
  );

  assign read_end = cross_evt || tmo_evt;

  dsadc_result #(
    .READ_MAX (READ_MAX),
    .CNT_W    (CNT_W)
  ) u_res (
    .clk      (clk),
    .rst      (rst),
    .read_end (read_end),
    .tmo_evt  (tmo_evt),
    .pol      (pol),
    .cnt      (cnt),
    .res_mag  (res_mag),
    .res_neg  (res_neg),
    .res_over (res_over),
    .res_vld  (res_vld)
  );

  assign sw      = phase_to_sw(phase);
  assign az_en   = sw.az;
  assign int_en  = sw.integ;
  assign rd_en   = sw.rd;
  assign ref_neg = sw.rd && pol;
endmodule

// File: rtl/dsadc_seq_chk.sv
module dsadc_seq_chk #(
  parameter int unsigned FIX_CYCLES = 1000,
  parameter int unsigned READ_MAX   = 2000,
  parameter int unsigned CNT_W      = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             az_en,
  input logic             int_en,
  input logic             rd_en,
  input logic             ref_neg,
  input logic [CNT_W-1:0] res_mag,
  input logic             res_neg,
  input logic             res_over,
  input logic             res_vld,
  input logic             fix_done,
  input logic             cross_evt,
  input logic             tmo_evt
);
  logic [2:0]  cur, cur_q;
  int unsigned run;
  logic        az_clean;

  assign cur = {az_en, int_en, rd_en};

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q    <= 3'b100;
      run      <= 0;
      az_clean <= 1'b0;
    end else begin
      cur_q <= cur;
      if (cur != cur_q) run <= 1;
      else if (run < 32'hFFFF_0000) run <= run + 1;
      if (res_vld) az_clean <= 1'b1;
      else if (int_en) az_clean <= 1'b0;
    end
  end

  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $countones({az_en, int_en, rd_en}) == 1);
  p_int_after_az_r2: assert property (@(posedge clk) disable iff (rst)
    (int_en && !$past(int_en)) |-> $past(az_en));
  p_rd_after_int_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !$past(rd_en)) |-> $past(int_en));
  p_az_after_rd_r2: assert property (@(posedge clk) disable iff (rst)
    (az_en && !$past(az_en)) |-> $past(rd_en));
  p_int_len_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !$past(rd_en)) |-> (run == FIX_CYCLES));
  p_az_len_r3: assert property (@(posedge clk) disable iff (rst)
    (int_en && $past(az_en) && az_clean) |-> (run == FIX_CYCLES));
  p_fix_not_read_r3: assert property (@(posedge clk) disable iff (rst)
    fix_done |-> !rd_en);
  p_ref_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && $past(rd_en)) |-> $stable(ref_neg));
  p_ref_off_r4: assert property (@(posedge clk) disable iff (rst)
    !rd_en |-> !ref_neg);
  p_cross_r5: assert property (@(posedge clk) disable iff (rst)
    cross_evt |=> (res_vld && !res_over));
  p_tmo_r7: assert property (@(posedge clk) disable iff (rst)
    tmo_evt |=> (res_vld && res_over));
  p_over_mag_r7: assert property (@(posedge clk) disable iff (rst)
    res_over |-> (res_mag == CNT_W'(READ_MAX)));
  p_vld_place_r8: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> (az_en && $past(rd_en)));
  p_vld_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    res_vld |=> !res_vld);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !res_vld |-> ($stable(res_mag) && $stable(res_neg) && $stable(res_over)));
endmodule

bind dsadc_seq dsadc_seq_chk #(
  .FIX_CYCLES (FIX_CYCLES),
  .READ_MAX   (READ_MAX),
  .CNT_W      (CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .az_en     (az_en),
  .int_en    (int_en),
  .rd_en     (rd_en),
  .ref_neg   (ref_neg),
  .res_mag   (res_mag),
  .res_neg   (res_neg),
  .res_over  (res_over),
  .res_vld   (res_vld),
  .fix_done  (fix_done),
  .cross_evt (cross_evt),
  .tmo_evt   (tmo_evt)
);

// File: tb/dsadc_seq_tb.sv
module dsadc_seq_tb;
  localparam int unsigned FIX  = 8;
  localparam int unsigned RMAX = 20;
  localparam int unsigned CW   = $clog2(RMAX + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmp_in = 1'b0;
  logic          az_en, int_en, rd_en, ref_neg;
  logic [CW-1:0] res_mag;
  logic          res_neg, res_over, res_vld;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  dsadc_seq #(.FIX_CYCLES(FIX), .READ_MAX(RMAX)) u_dut (
    .clk (clk), .rst (rst), .cmp_in (cmp_in),
    .az_en (az_en), .int_en (int_en), .rd_en (rd_en), .ref_neg (ref_neg),
    .res_mag (res_mag), .res_neg (res_neg), .res_over (res_over),
    .res_vld (res_vld)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wait_for_rd(output bit seen);
    seen = 0;
    for (int i = 0; i < 200 && !seen; i++) begin
      @(negedge clk);
      if (rd_en) seen = 1;
    end
  endtask

  task automatic wait_for_vld(output bit seen);
    seen = 0;
    for (int i = 0; i < 200 && !seen; i++) begin
      @(negedge clk);
      if (res_vld) seen = 1;
    end
  endtask

  // One conversion: pos = comparator level while integrating (1 = positive input),
  // d = read clock at which the comparator flips; tmo = never flip.
  task automatic measure(input bit pos, input int d, input bit tmo, input bit glitch);
    bit seen;
    int exp_mag;
    logic [CW-1:0] held;
    cmp_in = pos;
    if (glitch) begin
      while (!int_en) @(negedge clk);
      @(negedge clk);
      cmp_in = ~pos;
      repeat (2) @(negedge clk);
      cmp_in = pos;
    end
    wait_for_rd(seen);
    check(seen, "R2 read reached", int'(seen), 1);
    check(ref_neg == pos, "R4 ref select in read", int'(ref_neg), int'(pos));
    if (glitch) check(res_vld == 1'b0, "R9 no early end", int'(res_vld), 0);
    if (!tmo) begin
      repeat (d) @(negedge clk);
      cmp_in = ~pos;
    end
    wait_for_vld(seen);
    exp_mag = tmo ? RMAX : d + 2;
    check(seen, "R8 strobe seen", int'(seen), 1);
    check(int'(res_mag) == exp_mag, tmo ? "R7 timeout magnitude" : "R5 read count",
          int'(res_mag), exp_mag);
    check(res_over == tmo, "R7 overrange flag", int'(res_over), int'(tmo));
    check(res_neg == !pos, glitch ? "R9 polarity kept" : "R6 sign",
          int'(res_neg), int'(!pos));
    check(az_en == 1'b1, "R8 strobe on autozero", int'(az_en), 1);
    held = res_mag;
    @(negedge clk);
    check(res_vld == 1'b0, "R8 single pulse", int'(res_vld), 0);
    check(res_mag == held, "R8 result held", int'(res_mag), int'(held));
    check(ref_neg == 1'b0, "R4 ref off outside read", int'(ref_neg), 0);
  endtask

  initial begin
    bit seen;
    int n;
    repeat (3) @(negedge clk);
    check(az_en && !int_en && !rd_en, "R1 reset phase",
          int'({az_en, int_en, rd_en}), 4);
    check(!ref_neg && res_mag == 0 && !res_neg && !res_over && !res_vld,
          "R1 reset results", int'(res_mag), 0);
    rst = 1'b0;
    @(negedge clk);
    check(az_en && !res_vld, "R1 first clock after reset", int'(az_en), 1);

    // Phase lengths (R3) and ordering (R2)
    while (!int_en) @(negedge clk);
    n = 0;
    while (int_en) begin n++; @(negedge clk); end
    check(n == FIX, "R3 integrate length", n, FIX);
    check(rd_en == 1'b1, "R2 read follows integrate", int'(rd_en), 1);
    wait_for_vld(seen);
    check(seen && res_over, "R7 idle comparator times out", int'(res_over), 1);
    n = 0;
    while (az_en) begin n++; @(negedge clk); end
    check(n == FIX, "R3 autozero length", n, FIX);
    check(int_en == 1'b1, "R2 integrate follows autozero", int'(int_en), 1);

    // Sweep crossing times for both polarities (R5, R6); last value d=RMAX-3
    // lands on the final read clock where the crossing beats the timeout (R7)
    for (int p = 0; p < 2; p++) begin
      for (int d = 0; d <= int'(RMAX) - 3; d++) measure(p[0], d, 1'b0, 1'b0);
      measure(p[0], 0, 1'b1, 1'b0);
    end
    // Comparator glitch during integration is ignored (R9)
    measure(1'b1, 5, 1'b0, 1'b1);
    measure(1'b0, 9, 1'b0, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule